// File: doc/BRIEF.md
# Low-Order Interleaved Block Memory

This block is a read-only block store split across a power-of-two number of banks. A block address picks its bank from its low bits and its slot inside that bank from the remaining high bits. Consecutive block addresses therefore fall in consecutive banks, and their array accesses run at the same time. Each bank spends one cycle taking the address and ten cycles on its array access. One shared return path then carries the block as four data beats. Only that path is used one block at a time.

A requester offers one block address per cycle with a valid/ready handshake. Data comes back on the return path in the order the requests were accepted. A small queue of bank numbers keeps that order. The word a bank returns is a fixed pattern made from the bank number, the slot and the beat number, so a reader can tell where every beat came from.

Top module: `ilv_mem`

## Requirements
- R1: A block address A is served by bank A mod NUM_BANKS at slot A div NUM_BANKS. Each returned 32-bit word holds the bank number in bits [31:24], the slot in bits [23:8] and the beat number (0 to 3) in bits [7:0], all zero-extended.
- R2: Every block is returned as exactly BEATS (4) consecutive beats with resp_valid high. resp_last is high on the fourth beat only.
- R3: With the return path idle, a request accepted on clock edge E shows its first beat after edge E+11 and its last beat after edge E+14. The access takes 15 cycles in total.
- R4: Blocks come back in the order their requests were accepted, whatever banks they use.
- R5: req_ready is low exactly while the bank addressed by req_addr holds an accepted request whose transfer has not begun. Otherwise it is high.
- R6: Eight requests to consecutive block addresses, accepted on eight consecutive edges, end their last beat 43 cycles after the first acceptance. The blocks follow one another with no idle beat between them.
- R7: The return path carries one block at a time. Within a block the beat numbers run 0, 1, 2, 3 without interleaving.
- R8: While reset is held and right after it, resp_valid is low and req_ready is high.
- R9: An address presented with req_valid low starts no access and produces no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A block address is offered |
| req_ready | output | 1 | The addressed bank can take the request |
| req_addr | input | ADDR_W | Block address |
| resp_valid | output | 1 | A data beat is on resp_data |
| resp_data | output | 32 | Data beat |
| resp_last | output | 1 | Final beat of a block |

## Verification
In the same cycle, a new request can be accepted into one bank while the return path starts draining another bank and pops the order queue. The case that matters most is a request to the very bank being drained. Back-to-back bursts of consecutive addresses and same-bank pairs bring these events together on one edge. A bench model predicts the acceptance edge of every request, its first-beat cycle and the stall window of each bank. The bench then judges every beat by its cycle and content, and judges every offered cycle by the exact value of req_ready.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int WORD_W = 32;

    // Pattern word stored in every bank: bank, slot and beat number.
    function automatic logic [WORD_W-1:0] blk_word(input logic [7:0]  bank,
                                                   input logic [15:0] slot,
                                                   input logic [7:0]  beat);
        return {bank, slot, beat};
    endfunction

endpackage

// File: rtl/ilv_bank_unit.sv
module ilv_bank_unit #(
    parameter int IDX_W = 7,
    parameter int LAT_W = 4,
    parameter int LOAD  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    input  logic             drain,
    output logic             busy,
    output logic             data_rdy,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (drain) begin
            st_d.busy = 1'b0;
        end
        if (take) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LAT_W'(LOAD);
            st_d.idx  = take_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign data_rdy = st_q.busy && (st_q.cnt == '0);
    assign idx      = st_q.idx;

endmodule

// File: rtl/ilv_order_fifo.sv
module ilv_order_fifo #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ENT_W-1:0]           push_val,
    input  logic                       pop,
    output logic [ENT_W-1:0]           head,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     occ
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [PTR_W:0]              occ;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_val;
            st_d.wp           = st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        st_d.occ = st_q.occ + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.occ == '0);
    assign occ   = st_q.occ;

endmodule

// File: rtl/ilv_xfer_engine.sv
module ilv_xfer_engine
    import ilv_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int IDX_W  = 7,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_ok,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [IDX_W-1:0]  cand_idx,
    output logic              start,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    output logic              resp_last
);

    localparam int BEAT_W = $clog2(BEATS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [BANK_W-1:0] bank;
        logic [IDX_W-1:0]  idx;
    } xf_st_t;

    xf_st_t st_d, st_q;
    logic   path_free;

    assign path_free = !st_q.active || (st_q.beat == LAST_BEAT);
    assign start     = cand_ok && path_free;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.beat == LAST_BEAT) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
        if (start) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.bank   = cand_bank;
            st_d.idx    = cand_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.active;
    assign resp_last  = st_q.active && (st_q.beat == LAST_BEAT);
    assign resp_data  = blk_word(8'(st_q.bank), 16'(st_q.idx), 8'(st_q.beat));

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 10,
    parameter int ADDR_CYC  = 1,
    parameter int ARRAY_CYC = 10,
    parameter int BEATS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [31:0]       resp_data,
    output logic              resp_last
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = ADDR_W - BANK_W;
    localparam int LAT_W  = $clog2(ADDR_CYC + ARRAY_CYC);
    localparam int LOAD   = ADDR_CYC + ARRAY_CYC - 1;
    localparam int OCC_W  = BANK_W + 1;

    logic [BANK_W-1:0]    req_bank;
    logic [IDX_W-1:0]     req_idx;
    logic                 accept;
    logic [NUM_BANKS-1:0] bank_busy;
    logic [NUM_BANKS-1:0] bank_rdy;
    logic [IDX_W-1:0]     bank_idx [NUM_BANKS];
    logic [BANK_W-1:0]    head_bank;
    logic                 fifo_empty;
    logic [OCC_W-1:0]     fifo_occ;
    logic                 xf_start;
    logic                 cand_ok;

    assign req_bank  = req_addr[BANK_W-1:0];
    assign req_idx   = req_addr[ADDR_W-1:BANK_W];
    assign req_ready = !bank_busy[req_bank];
    assign accept    = req_valid && req_ready;
    assign cand_ok   = !fifo_empty && bank_rdy[head_bank];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ilv_bank_unit #(
            .IDX_W (IDX_W),
            .LAT_W (LAT_W),
            .LOAD  (LOAD)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (accept && (req_bank == BANK_W'(g))),
            .take_idx (req_idx),
            .drain    (xf_start && (head_bank == BANK_W'(g))),
            .busy     (bank_busy[g]),
            .data_rdy (bank_rdy[g]),
            .idx      (bank_idx[g])
        );
    end

    ilv_order_fifo #(
        .DEPTH (NUM_BANKS),
        .ENT_W (BANK_W)
    ) order_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_val (req_bank),
        .pop      (xf_start),
        .head     (head_bank),
        .empty    (fifo_empty),
        .occ      (fifo_occ)
    );

    ilv_xfer_engine #(
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W),
        .BEATS  (BEATS)
    ) xfer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_ok    (cand_ok),
        .cand_bank  (head_bank),
        .cand_idx   (bank_idx[head_bank]),
        .start      (xf_start),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .resp_last  (resp_last)
    );

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int NUM_BANKS = 8,
    parameter int IDX_W     = 7,
    parameter int BEATS     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input logic                         resp_valid,
    input logic [31:0]                  resp_data,
    input logic                         resp_last,
    input logic [$clog2(NUM_BANKS):0]   fifo_occ
);

    logic [7:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (resp_valid) begin
            seen_q <= resp_last ? 8'd0 : seen_q + 8'd1;
        end
    end

    AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_last |=> resp_valid); // R2

    AST_LAST_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_last == (int'(seen_q) == BEATS - 1))); // R2

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_data[7:0] == seen_q); // R7

    AST_SAME_BANK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !(req_valid && req_bank == $past(req_bank)) || !req_ready); // R5

    AST_ORDER_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_occ) <= NUM_BANKS); // R4

    AST_FIELDS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (int'(resp_data[31:24]) < NUM_BANKS) &&
                       (int'(resp_data[23:8]) < (1 << IDX_W))); // R1

endmodule

bind ilv_mem ilv_mem_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W),
    .BEATS     (BEATS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_bank   (req_bank),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_last  (resp_last),
    .fifo_occ   (fifo_occ)
);

// File: tb/ilv_mem_tb_top.sv
`timescale 1ns/1ps
module ilv_mem_tb_top;

    localparam int NB    = 8;
    localparam int AW    = 10;
    localparam int FIRST = 12;   // handshake cycle to first-beat cycle
    localparam int NBEAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          resp_valid;
    logic [31:0]   resp_data;
    logic          resp_last;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    int e_bank [0:1023];
    int e_idx  [0:1023];
    int e_acc  [0:1023];
    int e_start[0:1023];
    int wr = 0, rd = 0, beat_ctr = 0, bus_free = 0;
    int first_seen = 0, last_seen = 0, resp_cnt = 0;
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    ilv_mem #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .resp_last  (resp_last)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic longint word_of(input int b, input int i, input int beat);
        return (longint'(b) << 24) | (longint'(i) << 8) | longint'(beat);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    // Monitor: samples at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (req_valid) begin
                int b;
                bit bsy;
                b = int'(req_addr) % NB;
                bsy = 1'b0;
                for (int i = 0; i < wr; i++)
                    if (e_bank[i] == b && e_acc[i] < cyc && e_start[i] > cyc) bsy = 1'b1;
                chk(req_ready == !bsy, "R5 ready", req_ready, !bsy);
            end
            if (resp_valid) resp_cnt++;
            begin
                bit exp_v;
                exp_v = (rd < wr) && (cyc == e_start[rd] + beat_ctr);
                if (resp_valid || exp_v) begin
                    chk(resp_valid == exp_v, "R3 beat timing", resp_valid, exp_v);
                    if (resp_valid && exp_v) begin
                        chk(resp_data == word_of(e_bank[rd], e_idx[rd], beat_ctr),
                            "R1 R4 data", resp_data, word_of(e_bank[rd], e_idx[rd], beat_ctr));
                        chk(resp_last == (beat_ctr == NBEAT - 1), "R2 last",
                            resp_last, beat_ctr == NBEAT - 1);
                        if (beat_ctr == 0) first_seen = cyc;
                        if (beat_ctr == NBEAT - 1) last_seen = cyc;
                        beat_ctr++;
                        if (beat_ctr == NBEAT) begin
                            beat_ctr = 0;
                            rd++;
                        end
                    end
                end
            end
            if (req_valid && req_ready) begin
                int st;
                st = (cyc + FIRST > bus_free) ? cyc + FIRST : bus_free;
                e_bank[wr]  = int'(req_addr) % NB;
                e_idx[wr]   = int'(req_addr) / NB;
                e_acc[wr]   = cyc;
                e_start[wr] = st;
                bus_free    = st + NBEAT;
                wr++;
            end
        end
    end

    task automatic send(input int a);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = AW'(a);
        do @(negedge clk); while (!req_ready);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_addr  = AW'($urandom);
    endtask

    task automatic drain_all();
        idle();
        while (rd < wr) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int fa, pa, cnt0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(resp_valid == 1'b0, "R8 reset valid", resp_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8 post-reset valid", resp_valid, 0);
        chk(req_ready == 1'b1, "R8 post-reset ready", req_ready, 1);
        mon_en = 1'b1;

        // R3: isolated request
        fa = wr;
        send(37);
        drain_all();
        chk(first_seen == e_acc[fa] + FIRST, "R3 first beat", first_seen, e_acc[fa] + FIRST);
        chk(last_seen == e_acc[fa] + FIRST + 3, "R3 last beat", last_seen, e_acc[fa] + FIRST + 3);

        // R6: eight consecutive blocks back to back
        fa = wr;
        for (int k = 0; k < NB; k++) send(16 + k);
        drain_all();
        chk(e_acc[fa + NB - 1] == e_acc[fa] + NB - 1, "R6 back-to-back accept",
            e_acc[fa + NB - 1], e_acc[fa] + NB - 1);
        chk(last_seen == e_acc[fa] + 43, "R6 burst end", last_seen, e_acc[fa] + 43);

        // R5: same bank twice, second stalls until the first starts its transfer
        fa = wr;
        send(5);
        send(5 + NB);
        drain_all();
        chk(e_acc[fa + 1] == e_acc[fa] + FIRST, "R5 stall length",
            e_acc[fa + 1], e_acc[fa] + FIRST);

        // R4: descending banks keep request order
        fa = wr;
        send(3); send(2); send(1); send(9);
        drain_all();
        chk(rd == wr, "R4 all returned", rd, wr);

        // R9: addresses with valid low produce nothing
        cnt0 = resp_cnt;
        for (int k = 0; k < 30; k++) idle();
        chk(resp_cnt == cnt0, "R9 no beats", resp_cnt, cnt0);

        // R7 R4: random mix with runs of consecutive addresses
        pa = 0;
        for (int n = 0; n < 300; n++) begin
            int a;
            a = ($urandom % 3 != 0) ? (pa + 1) % (1 << AW) : int'($urandom % (1 << AW));
            send(a);
            pa = a;
            if ($urandom % 4 == 0) idle();
        end
        drain_all();
        chk(rd == wr, "R7 every block delivered", rd, wr);
        chk(beat_ctr == 0, "R7 no partial block", beat_ctr, 0);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule